// File: doc/BRIEF.md
# Register Rename Table with Tag Wakeup

This block merges the architectural register file and the rename map into one table indexed by register number. Each entry is in one of two states. A ready entry holds the register's current value. A waiting entry holds the tag of the in-flight instruction that will produce that value. A presence bit tells the two states apart.

In the decode stage the table serves two source lookups at once. Each lookup returns a (ready, value-or-tag) pair. In the same cycle, decode may claim a destination register by writing a newly allocated tag into it and marking it waiting. A result broadcast carries a tag and a value. Every waiting entry whose stored tag equals the broadcast tag takes the value and becomes ready.

Because each writer gets a fresh tag, a later writer can replace a mapping while earlier consumers still hold the older tag. This removes write-after-read and write-after-write hazards.

Top module: `rename_table`

## Requirements
- R1: After reset, every entry is ready and holds the value zero.
- R2: A lookup of a ready entry returns ready=1 and the stored value.
- R3: A rename (`dec_valid`=1 and `dec_dst_en`=1) makes the destination entry waiting on `dec_tag` from the next cycle on. A lookup of a waiting entry returns ready=0, with the tag in bits [TAG_W-1:0] of the value output and zeros above them.
- R4: A broadcast whose tag matches a waiting entry stores the broadcast data in that entry and makes it ready from the next cycle.
- R5: A broadcast has no effect on a ready entry, even when the low bits of that entry's value equal the broadcast tag.
- R6: A broadcast that matches a looked-up waiting entry in the same cycle is forwarded to the output, which then shows ready=1 and the broadcast data.
- R7: Source lookups see the table as it was before the same cycle's rename, so a source equal to the destination returns the old mapping.
- R8: If a broadcast matches an entry that is renamed in the same cycle, the rename wins, and the entry waits on the new tag.
- R9: After an entry is renamed again, a broadcast of its older tag leaves it waiting.
- R10: With `dec_valid`=0 or `dec_dst_en`=0, no entry is renamed.
- R11: The two lookup ports are independent: each returns the state of its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_src0 | input | IDX_W | First source register index |
| dec_src1 | input | IDX_W | Second source register index |
| dec_dst_en | input | 1 | Instruction writes a destination |
| dec_dst | input | IDX_W | Destination register index |
| dec_tag | input | TAG_W | Newly allocated producer tag |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the finishing producer |
| bc_data | input | DATA_W | Result value |
| src0_ready | output | 1 | First source value is available |
| src0_val | output | DATA_W | First source value, or its tag when not ready |
| src1_ready | output | 1 | Second source value is available |
| src1_val | output | DATA_W | Second source value, or its tag when not ready |

## Verification
The assertions assume the following about the inputs:
- A tag is never live in two waiting entries at once. The tag allocator elsewhere guarantees this.
- At most one broadcast arrives per cycle.
- DATA_W is wider than TAG_W.

The stimulus keeps to these rules. It draws every renamed tag from values that are not currently outstanding, with one exception: the write-after-write case deliberately reuses a register, and it still gives that register a fresh tag. Inputs change only on the falling clock edge, so the combinational lookup outputs are stable when they are sampled and when the next rising edge captures state.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int RNM_REGS = 16;
  localparam int RNM_DW   = 16;
  localparam int RNM_TW   = 4;
endpackage

// File: rtl/rnm_entry.sv
module rnm_entry
  import rnm_pkg::*;
#(
  parameter int DW = RNM_DW,
  parameter int TW = RNM_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rename,
  input  logic [TW-1:0] wr_tag,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  output logic          present,
  output logic [DW-1:0] field
);
  localparam int PADW = DW - TW;

  function automatic logic [DW-1:0] tag_to_field(input logic [TW-1:0] t);
    return {{PADW{1'b0}}, t};
  endfunction

  logic bc_hit;
  assign bc_hit = bc_valid && !present && (field[TW-1:0] == bc_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= 1'b1;
      field   <= '0;
    end else if (wr_rename) begin
      present <= 1'b0;
      field   <= tag_to_field(wr_tag);
    end else if (bc_hit) begin
      present <= 1'b1;
      field   <= bc_data;
    end
  end

  a_r3_rename_waits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rename |=> (!present && field == {{PADW{1'b0}}, $past(wr_tag)}));

  a_r4_fill_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_hit && !wr_rename) |=> (present && field == $past(bc_data)));

  a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (present && !wr_rename) |=> (present && $stable(field)));
endmodule

// File: rtl/rnm_rdport.sv
module rnm_rdport
  import rnm_pkg::*;
#(
  parameter int NREGS = RNM_REGS,
  parameter int DW    = RNM_DW,
  parameter int TW    = RNM_TW,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IW-1:0]             idx,
  input  logic [NREGS-1:0]          ent_present,
  input  logic [NREGS-1:0][DW-1:0]  ent_field,
  input  logic                      bc_valid,
  input  logic [TW-1:0]             bc_tag,
  input  logic [DW-1:0]             bc_data,
  output logic                      ready,
  output logic [DW-1:0]             val
);
  function automatic logic forward_hit(input logic pres, input logic [TW-1:0] held,
                                       input logic bv, input logic [TW-1:0] bt);
    return bv && !pres && (held == bt);
  endfunction

  logic          sel_present;
  logic [DW-1:0] sel_field;
  logic          fwd;

  always_comb begin
    sel_present = ent_present[idx];
    sel_field   = ent_field[idx];
    fwd         = forward_hit(sel_present, sel_field[TW-1:0], bc_valid, bc_tag);
    ready       = sel_present || fwd;
    val         = fwd ? bc_data : sel_field;
  end

  a_r2_ready_entry_read: assert property (@(posedge clk) disable iff (!rst_n)
    ent_present[idx] |-> (ready && val == ent_field[idx]));
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rnm_pkg::*;
#(
  parameter int NREGS  = RNM_REGS,
  parameter int DATA_W = RNM_DW,
  parameter int TAG_W  = RNM_TW,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [IDX_W-1:0]  dec_src0,
  input  logic [IDX_W-1:0]  dec_src1,
  input  logic              dec_dst_en,
  input  logic [IDX_W-1:0]  dec_dst,
  input  logic [TAG_W-1:0]  dec_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              src0_ready,
  output logic [DATA_W-1:0] src0_val,
  output logic              src1_ready,
  output logic [DATA_W-1:0] src1_val
);
  logic [NREGS-1:0]             ent_present;
  logic [NREGS-1:0][DATA_W-1:0] ent_field;
  logic [NREGS-1:0]             rename_sel;
  logic                         rename_fire;

  assign rename_fire = dec_valid && dec_dst_en;

  for (genvar g = 0; g < NREGS; g++) begin : g_ent
    assign rename_sel[g] = rename_fire && (dec_dst == IDX_W'(g));
    rnm_entry #(.DW(DATA_W), .TW(TAG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_rename (rename_sel[g]),
      .wr_tag    (dec_tag),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .present   (ent_present[g]),
      .field     (ent_field[g])
    );
  end

  logic [1:0]             rd_ready;
  logic [1:0][DATA_W-1:0] rd_val;
  logic [1:0][IDX_W-1:0]  rd_idx;
  assign rd_idx[0] = dec_src0;
  assign rd_idx[1] = dec_src1;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    rnm_rdport #(.NREGS(NREGS), .DW(DATA_W), .TW(TAG_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx         (rd_idx[p]),
      .ent_present (ent_present),
      .ent_field   (ent_field),
      .bc_valid    (bc_valid),
      .bc_tag      (bc_tag),
      .bc_data     (bc_data),
      .ready       (rd_ready[p]),
      .val         (rd_val[p])
    );
  end

  assign src0_ready = rd_ready[0];
  assign src0_val   = rd_val[0];
  assign src1_ready = rd_ready[1];
  assign src1_val   = rd_val[1];

  a_r10_no_rename_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rename_fire |-> (rename_sel == '0));

  a_r8_single_rename: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rename_sel));

  // R6: a forwarded value becomes the entry's stored value one cycle later
  a_r6_forward_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_present[dec_src0] && src0_ready && !rename_sel[dec_src0])
      |=> (ent_present[$past(dec_src0)] && ent_field[$past(dec_src0)] == $past(src0_val)));
endmodule

// File: tb/rename_table_tb.sv
module rename_table_tb;
  localparam int NREGS = 16;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_dst_en = 1'b0, bc_valid = 1'b0;
  logic [IW-1:0] dec_src0 = '0, dec_src1 = '0, dec_dst = '0;
  logic [TW-1:0] dec_tag = '0, bc_tag = '0;
  logic [DW-1:0] bc_data = '0;
  logic src0_ready, src1_ready;
  logic [DW-1:0] src0_val, src1_val;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rename_table #(.NREGS(NREGS), .DATA_W(DW), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src0(dec_src0),
    .dec_src1(dec_src1), .dec_dst_en(dec_dst_en), .dec_dst(dec_dst),
    .dec_tag(dec_tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src0_ready(src0_ready), .src0_val(src0_val),
    .src1_ready(src1_ready), .src1_val(src1_val));

  typedef struct packed {
    logic          dv;
    logic [IW-1:0] s0;
    logic [IW-1:0] s1;
    logic          de;
    logic [IW-1:0] dst;
    logic [TW-1:0] tag;
    logic          bv;
    logic [TW-1:0] btag;
    logic [DW-1:0] bdata;
    logic          r0;
    logic [DW-1:0] v0;
    logic          r1;
    logic [DW-1:0] v1;
  } vec_t;

  // Each row: drive, sample the outputs in the same cycle, then a rising edge.
  localparam vec_t VECS [10] = '{
    // R2: reset values; rename r1 -> tag 3
    '{1'b1, 4'd1, 4'd2, 1'b1, 4'd1, 4'd3, 1'b0, 4'd0, 16'h0000, 1'b1, 16'h0000, 1'b1, 16'h0000},
    // R3 / R11: r1 waits on tag 3 on both ports; rename r2 -> tag 5
    '{1'b1, 4'd1, 4'd1, 1'b1, 4'd2, 4'd5, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0003, 1'b0, 16'h0003},
    // R6: tag 3 broadcast forwarded on port 0; port 1 still waits on tag 5
    '{1'b1, 4'd1, 4'd2, 1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 16'h00AA, 1'b1, 16'h00AA, 1'b0, 16'h0005},
    // R4: r1 now holds the value
    '{1'b1, 4'd1, 4'd2, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'h00AA, 1'b0, 16'h0005},
    // R7: source r2 equals destination r2; old tag 5 read; rename r2 -> tag 7
    '{1'b1, 4'd2, 4'd3, 1'b1, 4'd2, 4'd7, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0005, 1'b1, 16'h0000},
    // R9: broadcast of old tag 5 leaves r2 waiting on tag 7
    '{1'b1, 4'd2, 4'd3, 1'b0, 4'd0, 4'd0, 1'b1, 4'd5, 16'h1234, 1'b0, 16'h0007, 1'b1, 16'h0000},
    // R8: tag 7 broadcast and rename of r2 -> tag 9 in one cycle; lookup forwards
    '{1'b1, 4'd2, 4'd3, 1'b1, 4'd2, 4'd9, 1'b1, 4'd7, 16'h0BEE, 1'b1, 16'h0BEE, 1'b1, 16'h0000},
    // R8 result: r2 waits on tag 9. R10: dec_valid=0 with destination r1
    '{1'b0, 4'd2, 4'd1, 1'b1, 4'd1, 4'd2, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0009, 1'b1, 16'h00AA},
    // R5: broadcast tag 0xA against ready r1 (low bits 0xA)
    '{1'b1, 4'd1, 4'd4, 1'b0, 4'd0, 4'd0, 1'b1, 4'hA, 16'h5555, 1'b1, 16'h00AA, 1'b1, 16'h0000},
    // R5 / R10 follow-up: r1 unchanged, r2 still waiting on tag 9
    '{1'b1, 4'd1, 4'd2, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'h00AA, 1'b0, 16'h0009}
  };

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dec_valid = 1'b0; dec_dst_en = 1'b0; bc_valid = 1'b0;
    dec_dst = '0; dec_tag = '0; bc_tag = '0; bc_data = '0;
  endtask

  initial begin : watchdog
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every entry ready and zero after reset
    for (int i = 0; i < NREGS; i += 2) begin
      @(negedge clk);
      dec_src0 = IW'(i); dec_src1 = IW'(i + 1);
      #1;
      check("R1 port0", {src0_ready, src0_val}, {1'b1, 16'h0000});
      check("R1 port1", {src1_ready, src1_val}, {1'b1, 16'h0000});
    end

    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      dec_valid = VECS[k].dv; dec_src0 = VECS[k].s0; dec_src1 = VECS[k].s1;
      dec_dst_en = VECS[k].de; dec_dst = VECS[k].dst; dec_tag = VECS[k].tag;
      bc_valid = VECS[k].bv; bc_tag = VECS[k].btag; bc_data = VECS[k].bdata;
      #1;
      check($sformatf("vector %0d port0 (R2-R10 see table)", k),
            {src0_ready, src0_val}, {VECS[k].r0, VECS[k].v0});
      check($sformatf("vector %0d port1 (R11)", k),
            {src1_ready, src1_val}, {VECS[k].r1, VECS[k].v1});
    end

    // R10: dec_dst_en=0 with dec_valid=1 does not rename r6
    @(negedge clk);
    idle_inputs();
    dec_valid = 1'b1; dec_dst = 4'd6; dec_tag = 4'd4;
    @(negedge clk);
    idle_inputs();
    dec_src0 = 4'd6; dec_src1 = 4'd2;
    #1;
    check("R10 dst_en low", {src0_ready, src0_val}, {1'b1, 16'h0000});
    check("R3 r2 tag 9", {src1_ready, src1_val}, {1'b0, 16'h0009});

    // R4: tag 9 broadcast fills r2; broadcast removed before the read
    @(negedge clk);
    bc_valid = 1'b1; bc_tag = 4'd9; bc_data = 16'hCAFE;
    @(negedge clk);
    idle_inputs();
    dec_src0 = 4'd2;
    #1;
    check("R4 fill r2", {src0_ready, src0_val}, {1'b1, 16'hCAFE});

    // R1: reset clears a pending mapping
    @(negedge clk);
    dec_valid = 1'b1; dec_dst_en = 1'b1; dec_dst = 4'd5; dec_tag = 4'd1;
    @(negedge clk);
    idle_inputs();
    dec_src0 = 4'd5;
    #1;
    check("R3 r5 waits", {src0_ready, src0_val}, {1'b0, 16'h0001});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    dec_src0 = 4'd5; dec_src1 = 4'd1;
    #1;
    check("R1 r5 after reset", {src0_ready, src0_val}, {1'b1, 16'h0000});
    check("R1 r1 after reset", {src1_ready, src1_val}, {1'b1, 16'h0000});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule